// File: doc/BRIEF.md
# Debug Register Access Port

This block is the software-facing access port for a bank of eight debug register indices. Indices 0 to 3 hold breakpoint addresses, indices 6 and 7 hold the debug status word and the debug control word, and indices 4 and 5 are aliases. With the debug-extensions mode bit clear, an access to 4 or 5 is steered to 6 or 7. With the mode bit set, such an access is refused with an invalid-opcode fault.

Status and control writes are screened against a reserved-bit mask. A write that sets any reserved bit is dropped and raises a general-protection fault with a zero error code. An accepted write has a fixed-one pattern merged into it before it is stored.

The port also feeds the breakpoint matcher that sits beside it. It presents the stored control, status and address values. It pulses a per-slot re-arm strobe when the address of a live, non-I/O slot is rewritten. It keeps an I/O-breakpoint-active flag, which is recomputed on every accepted control write.

Top module: `dbg_reg_port`

## Requirements
- R1: After reset, all address slots read 0, status reads `STS_ONES` (default 0xFFFF0FF0), control reads `CTL_ONES` (default 0x400), the I/O flag is low and both fault outputs are low.
- R2: A write to index 0 to 3 stores the data unchanged, including bits that are reserved for status and control, and raises no fault. A read (`acc_rd` high) returns the stored value of the resolved index in the same cycle. `acc_rdata` is 0 when no read is requested or the access faults.
- R3: With `ext_mode` low, index 4 reads and writes the status register and index 5 reads and writes the control register.
- R4: With `ext_mode` high, any read or write of index 4 or 5 raises `fault_ud` in the cycle after the access, drives `acc_rdata` to 0 and changes no register.
- R5: An accepted status write stores `wdata | STS_ONES`.
- R6: An accepted control write stores `wdata | CTL_ONES`.
- R7: A status or control write with any bit of `RSVD_MASK` set (default: bits 63:32) raises `fault_gp` in the next cycle, with `gp_code` equal to 0, and leaves the register unchanged.
- R8: A write to address slot i pulses `rearm[i]` for one cycle in the following cycle, but only when the control word in force at the time has slot i enabled and its type field is not I/O. Slot i is enabled when control bit 2i or 2i+1 is set. Its type field is control bits 17+4i:16+4i, and 2'b10 means I/O. Otherwise `rearm` stays 0.
- R9: After an accepted control write, `io_bp_active` is high when at least one slot is enabled with type 2'b10, and low otherwise. No other access changes it.
- R10: Each faulting access produces a fault pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_idx | input | 3 | Debug register index |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | XLEN | Write data |
| ext_mode | input | 1 | Debug-extensions mode; set makes indices 4/5 fault |
| acc_rdata | output | XLEN | Read data, same cycle |
| fault_ud | output | 1 | Invalid-opcode fault pulse |
| fault_gp | output | 1 | General-protection fault pulse |
| gp_code | output | 16 | Error code that accompanies `fault_gp` (always 0) |
| ctl_out | output | XLEN | Stored control word |
| sts_out | output | XLEN | Stored status word |
| addr_out | output | NUM_SLOTS*XLEN | Stored addresses, slot 0 in the low bits |
| rearm | output | NUM_SLOTS | Per-slot re-arm pulse |
| io_bp_active | output | 1 | Some slot is an enabled I/O breakpoint |

## Verification
The hardest situation to reach is the re-arm decision. It depends on the control word already stored, not on the write in flight, so the stimulus first installs control words that make a slot live, then make it I/O-typed, then make it enabled only through its global bit. After each of these, the stimulus rewrites the slot addresses. The alias-fault path is driven with both read and write strobes while the mode bit is set. The status and control values are then compared before and after the access to show that nothing moved. `io_bp_active` is also checked after a status write to show that only control writes move it.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    localparam int IDX_W    = 3;
    localparam int IDX_STS  = 6;
    localparam int IDX_CTL  = 7;
    localparam int TYPE_LSB = 16;

    typedef enum logic [1:0] {
        KIND_EXEC  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_IO    = 2'b10,
        KIND_ACCESS= 2'b11
    } bp_kind_e;

    function automatic logic is_alias_idx(input logic [IDX_W-1:0] idx);
        return idx == 3'd4 || idx == 3'd5;
    endfunction
endpackage

// File: rtl/dbg_idx_resolve.sv
module dbg_idx_resolve
    import dbg_pkg::*;
(
    input  logic [IDX_W-1:0] idx_in,
    input  logic             any_access,
    input  logic             ext_mode,
    output logic [IDX_W-1:0] idx_eff,
    output logic             alias_fault
);
    logic aliased;

    always_comb begin
        aliased     = is_alias_idx(idx_in);
        alias_fault = any_access && aliased && ext_mode;
        if (aliased && !ext_mode) idx_eff = idx_in + IDX_W'(2);
        else                      idx_eff = idx_in;
    end
endmodule

// File: rtl/dbg_ctl_decode.sv
module dbg_ctl_decode
    import dbg_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int NUM_SLOTS = 4
) (
    input  logic [XLEN-1:0]      ctl,
    output logic [NUM_SLOTS-1:0] slot_en,
    output logic [NUM_SLOTS-1:0] slot_io,
    output logic                 io_any
);
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        localparam int EN_LSB = 2 * s;
        localparam int TY_LSB = TYPE_LSB + 4 * s;
        bp_kind_e kind;
        always_comb begin
            kind       = bp_kind_e'(ctl[TY_LSB +: 2]);
            slot_en[s] = |ctl[EN_LSB +: 2];
            slot_io[s] = (kind == KIND_IO);
        end
    end

    assign io_any = |(slot_en & slot_io);
endmodule

// File: rtl/dbg_reg_port.sv
module dbg_reg_port
    import dbg_pkg::*;
#(
    parameter int              XLEN      = 64,
    parameter int              NUM_SLOTS = 4,
    parameter logic [XLEN-1:0] STS_ONES  = XLEN'(32'hFFFF_0FF0),
    parameter logic [XLEN-1:0] CTL_ONES  = XLEN'(32'h0000_0400),
    parameter logic [XLEN-1:0] RSVD_MASK = {{(XLEN-32){1'b1}}, 32'h0}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                acc_idx,
    input  logic                      acc_wr,
    input  logic                      acc_rd,
    input  logic [XLEN-1:0]           acc_wdata,
    input  logic                      ext_mode,
    output logic [XLEN-1:0]           acc_rdata,
    output logic                      fault_ud,
    output logic                      fault_gp,
    output logic [15:0]               gp_code,
    output logic [XLEN-1:0]           ctl_out,
    output logic [XLEN-1:0]           sts_out,
    output logic [NUM_SLOTS*XLEN-1:0] addr_out,
    output logic [NUM_SLOTS-1:0]      rearm,
    output logic                      io_bp_active
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][XLEN-1:0] addr;
        logic [XLEN-1:0]                sts;
        logic [XLEN-1:0]                ctl;
        logic                           ud;
        logic                           gp;
        logic [NUM_SLOTS-1:0]           rearm;
        logic                           io_act;
    } port_state_t;

    port_state_t st_d, st_q;

    logic [IDX_W-1:0]     idx_eff;
    logic                 alias_fault;
    logic [NUM_SLOTS-1:0] en_cur, io_cur, en_new, io_new;
    logic                 io_any_cur, io_any_new;
    logic [XLEN-1:0]      ctl_cand;
    logic                 rsvd_hit;

    dbg_idx_resolve u_resolve (
        .idx_in     (acc_idx),
        .any_access (acc_wr || acc_rd),
        .ext_mode   (ext_mode),
        .idx_eff    (idx_eff),
        .alias_fault(alias_fault)
    );

    dbg_ctl_decode #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS)) u_dec_cur (
        .ctl    (st_q.ctl),
        .slot_en(en_cur),
        .slot_io(io_cur),
        .io_any (io_any_cur)
    );

    assign ctl_cand = acc_wdata | CTL_ONES;
    assign rsvd_hit = |(acc_wdata & RSVD_MASK);

    dbg_ctl_decode #(.XLEN(XLEN), .NUM_SLOTS(NUM_SLOTS)) u_dec_new (
        .ctl    (ctl_cand),
        .slot_en(en_new),
        .slot_io(io_new),
        .io_any (io_any_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ud    = 1'b0;
        st_d.gp    = 1'b0;
        st_d.rearm = '0;
        if (alias_fault) begin
            st_d.ud = 1'b1;
        end else if (acc_wr) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (idx_eff == IDX_W'(s)) begin
                    st_d.addr[s]  = acc_wdata;
                    st_d.rearm[s] = en_cur[s] && !io_cur[s];
                end
            end
            if (idx_eff == IDX_W'(IDX_STS) || idx_eff == IDX_W'(IDX_CTL)) begin
                if (rsvd_hit) begin
                    st_d.gp = 1'b1;
                end else if (idx_eff == IDX_W'(IDX_STS)) begin
                    st_d.sts = acc_wdata | STS_ONES;
                end else begin
                    st_d.ctl    = ctl_cand;
                    st_d.io_act = io_any_new;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr   <= '0;
            st_q.sts    <= STS_ONES;
            st_q.ctl    <= CTL_ONES;
            st_q.ud     <= 1'b0;
            st_q.gp     <= 1'b0;
            st_q.rearm  <= '0;
            st_q.io_act <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_rd && !alias_fault) begin
            for (int s = 0; s < NUM_SLOTS; s++)
                if (idx_eff == IDX_W'(s)) acc_rdata = st_q.addr[s];
            if (idx_eff == IDX_W'(IDX_STS)) acc_rdata = st_q.sts;
            if (idx_eff == IDX_W'(IDX_CTL)) acc_rdata = st_q.ctl;
        end
    end

    assign fault_ud     = st_q.ud;
    assign fault_gp     = st_q.gp;
    assign gp_code      = 16'h0000;
    assign ctl_out      = st_q.ctl;
    assign sts_out      = st_q.sts;
    assign addr_out     = st_q.addr;
    assign rearm        = st_q.rearm;
    assign io_bp_active = st_q.io_act;

    AST_UD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ud |-> $past((acc_wr || acc_rd) && is_alias_idx(acc_idx) && ext_mode)); // R4
    AST_UD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ud |-> ($stable(ctl_out) && $stable(sts_out) && $stable(addr_out))); // R4
    AST_GP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault_gp |-> ($stable(ctl_out) && $stable(sts_out) && gp_code == 16'h0)); // R7
    AST_STS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_out & STS_ONES) == STS_ONES); // R5
    AST_CTL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_out & CTL_ONES) == CTL_ONES); // R6
    AST_REARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rearm)); // R8
    AST_IO_TRACKS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctl_out) |-> (io_bp_active == io_any_cur)); // R9
    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_ud && fault_gp)); // R10
endmodule

// File: tb/dbg_reg_port_bench.sv
module dbg_reg_port_bench;
    localparam int XLEN = 64;
    localparam int NS   = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      acc_idx = '0;
    logic            acc_wr = 1'b0, acc_rd = 1'b0, ext_mode = 1'b0;
    logic [XLEN-1:0] acc_wdata = '0;
    logic [XLEN-1:0] acc_rdata, ctl_out, sts_out;
    logic            fault_ud, fault_gp, io_bp_active;
    logic [15:0]     gp_code;
    logic [NS*XLEN-1:0] addr_out;
    logic [NS-1:0]   rearm;

    always #4 clk = ~clk;

    dbg_reg_port u_dbg_reg_port (
        .clk(clk), .rst_n(rst_n), .acc_idx(acc_idx), .acc_wr(acc_wr),
        .acc_rd(acc_rd), .acc_wdata(acc_wdata), .ext_mode(ext_mode),
        .acc_rdata(acc_rdata), .fault_ud(fault_ud), .fault_gp(fault_gp),
        .gp_code(gp_code), .ctl_out(ctl_out), .sts_out(sts_out),
        .addr_out(addr_out), .rearm(rearm), .io_bp_active(io_bp_active)
    );

    typedef enum int {S_RD, S_UD, S_GP, S_CODE, S_CTL, S_STS, S_IO, S_REARM} sel_e;
    typedef struct {
        int              due;
        sel_e            sel;
        logic [XLEN-1:0] exp;
        string           req;
    } item_t;

    item_t scb[$];
    int cyc = 0, c_now = 0, n_chk = 0, n_bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [XLEN-1:0] sample(sel_e s);
        case (s)
            S_RD:    return acc_rdata;
            S_UD:    return XLEN'(fault_ud);
            S_GP:    return XLEN'(fault_gp);
            S_CODE:  return XLEN'(gp_code);
            S_CTL:   return ctl_out;
            S_STS:   return sts_out;
            S_IO:    return XLEN'(io_bp_active);
            default: return XLEN'(rearm);
        endcase
    endfunction

    always @(negedge clk) begin
        for (int i = scb.size() - 1; i >= 0; i--) begin
            if (scb[i].due == cyc) begin
                logic [XLEN-1:0] act;
                act = sample(scb[i].sel);
                n_chk++;
                if (act !== scb[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%s act=%h exp=%h", scb[i].req,
                             scb[i].sel.name(), act, scb[i].exp);
                end
                scb.delete(i);
            end
        end
    end

    task automatic op(input logic [2:0] idx, input logic wr, input logic rd,
                      input logic [XLEN-1:0] d, input logic ext);
        @(posedge clk); #2;
        acc_idx = idx; acc_wr = wr; acc_rd = rd; acc_wdata = d; ext_mode = ext;
        c_now = cyc;
    endtask

    task automatic idle();
        op(3'd0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic expect_at(input int off, input sel_e s,
                             input logic [XLEN-1:0] v, input string req);
        item_t it;
        it.due = c_now + off; it.sel = s; it.exp = v; it.req = req;
        scb.push_back(it);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        for (int k = 0; k < 4; k++) begin
            op(3'(k), 1'b0, 1'b1, '0, 1'b0);
            expect_at(0, S_RD, '0, "R1");
        end
        expect_at(0, S_STS, 64'hFFFF_0FF0, "R1");
        expect_at(0, S_CTL, 64'h400, "R1");
        expect_at(0, S_IO, 0, "R1");
        expect_at(0, S_UD, 0, "R1");
        expect_at(0, S_GP, 0, "R1");
        // R2 address store and same-cycle read
        op(3'd1, 1'b1, 1'b0, 64'hDEAD_BEEF_1234_5678, 1'b0);
        expect_at(1, S_REARM, 0, "R8");
        op(3'd1, 1'b0, 1'b1, '0, 1'b0);
        expect_at(0, S_RD, 64'hDEAD_BEEF_1234_5678, "R2");
        // R5 status fixed ones, R3 alias read
        op(3'd6, 1'b1, 1'b0, 64'h4001, 1'b0);
        expect_at(1, S_STS, 64'hFFFF_4FF1, "R5");
        op(3'd4, 1'b0, 1'b1, '0, 1'b0);
        expect_at(0, S_RD, 64'hFFFF_4FF1, "R3");
        // R3 alias write to control, R6
        op(3'd5, 1'b1, 1'b0, 64'h3, 1'b0);
        expect_at(1, S_CTL, 64'h403, "R6");
        expect_at(1, S_IO, 0, "R9");
        // R8 re-arm on live exec slot
        op(3'd0, 1'b1, 1'b0, 64'h1000, 1'b0);
        expect_at(1, S_REARM, 64'h1, "R8");
        op(3'd2, 1'b1, 1'b0, 64'hFFFF_0000_0000_2000, 1'b0);
        expect_at(1, S_REARM, 0, "R8");
        expect_at(1, S_GP, 0, "R2");
        op(3'd2, 1'b0, 1'b1, '0, 1'b0);
        expect_at(0, S_RD, 64'hFFFF_0000_0000_2000, "R2");
        // R9 I/O slot enabled
        op(3'd7, 1'b1, 1'b0, 64'h0020_0004, 1'b0);
        expect_at(1, S_CTL, 64'h0020_0404, "R6");
        expect_at(1, S_IO, 1, "R9");
        op(3'd1, 1'b1, 1'b0, 64'h60, 1'b0);
        expect_at(1, S_REARM, 0, "R8");
        op(3'd6, 1'b1, 1'b0, 64'h0, 1'b0);
        expect_at(1, S_STS, 64'hFFFF_0FF0, "R5");
        expect_at(1, S_IO, 1, "R9");
        // R4 alias with extensions set
        op(3'd4, 1'b1, 1'b0, 64'h5, 1'b1);
        expect_at(1, S_UD, 1, "R4");
        expect_at(1, S_STS, 64'hFFFF_0FF0, "R4");
        op(3'd5, 1'b0, 1'b1, '0, 1'b1);
        expect_at(0, S_RD, 0, "R4");
        expect_at(1, S_UD, 1, "R4");
        expect_at(1, S_CTL, 64'h0020_0404, "R4");
        idle();
        expect_at(1, S_UD, 0, "R10");
        // R7 reserved bits
        op(3'd7, 1'b1, 1'b0, 64'h1_0000_0000, 1'b0);
        expect_at(1, S_GP, 1, "R7");
        expect_at(1, S_CODE, 0, "R7");
        expect_at(1, S_CTL, 64'h0020_0404, "R7");
        idle();
        expect_at(1, S_GP, 0, "R10");
        op(3'd6, 1'b1, 1'b0, 64'h8000_0000_0000_0001, 1'b0);
        expect_at(1, S_GP, 1, "R7");
        expect_at(1, S_STS, 64'hFFFF_0FF0, "R7");
        // R9 clear, R8 global-only enable
        op(3'd7, 1'b1, 1'b0, 64'h1000_0080, 1'b0);
        expect_at(1, S_CTL, 64'h1000_0480, "R6");
        expect_at(1, S_IO, 0, "R9");
        op(3'd3, 1'b1, 1'b0, 64'h77, 1'b0);
        expect_at(1, S_REARM, 64'h8, "R8");
        op(3'd3, 1'b0, 1'b1, '0, 1'b0);
        expect_at(0, S_RD, 64'h77, "R2");
        idle();
        expect_at(1, S_REARM, 0, "R8");
        repeat (4) @(posedge clk);
        if (scb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard act=%0d pending exp=0", scb.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule